// File: doc/BRIEF.md
# Dual-Slope Integrating Converter Sequencer

This block is the digital sequencer of a dual-slope integrating analog-to-digital converter. The integrator, its analog switches and the zero-crossing comparator sit outside the block. The block drives two outputs to them: a clear line that holds the integrator at zero, and a source select that connects either the unknown input or the negative reference. It reads the comparator back through a synchronizer.

A conversion starts with a start pulse. The block integrates the input for exactly 2^N clocks. It then switches to the reference and counts clocks until the comparator reports that the integrator is no longer above zero. That count is the result, equal to the input-to-reference ratio scaled by 2^N. The block removes the fixed delay of the synchronizer from the count.

The result leaves the block on a valid/ready port. Valid rises when the count is final. The code and the overrange flag then stay frozen until the consumer asserts ready, and that is the only back-pressure. While a result waits, the block cannot start a new conversion. A run-down that has not ended when the count reaches full scale is cut short: the code saturates and the overrange flag is raised.

Top module: `dsc_ctrl`

## Requirements
- R1: During and after reset, `int_clr_o` is 1 and `ref_sel_o`, `res_valid_o`, `code_o` and `ovr_o` are 0.
- R2: A start pulse seen while idle, with no result pending, makes `int_clr_o` 0 and `ref_sel_o` 0 (input connected) from the next cycle on.
- R3: The run-up, during which `int_clr_o`=0 and `ref_sel_o`=0, lasts exactly 2^N clock cycles. It is followed directly by the run-down with `ref_sel_o`=1 (reference connected).
- R4: `cmp_i`=1 means the integrator is above zero. The run-down ends on the synchronized comparator. For an integrator that gains Vin per run-up cycle and loses Vref per run-down cycle, `code_o` is the smallest k with k·Vref ≥ 2^N·Vin, and it is 0 for a zero input. The two-cycle synchronizer delay does not appear in the code.
- R5: If that k exceeds 2^N−1, `code_o` is all ones and `ovr_o` is 1. Otherwise `ovr_o` is 0.
- R6: While `res_valid_o` is 1 and `res_ready_i` is 0, `res_valid_o`, `code_o` and `ovr_o` hold. In the cycle after `res_valid_o` and `res_ready_i` are both 1, `res_valid_o` is 0.
- R7: `int_clr_o` is 1 whenever no conversion is running, including while a result waits. `ref_sel_o` is 1 only during the run-down.
- R8: A start pulse during a conversion, or while a result waits, has no effect. The running conversion keeps its timing and code, and no new conversion begins after the result is taken.
- R9: A conversion keeps `int_clr_o` low for at most 2^(N+1)+2 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a conversion when idle |
| cmp_i | input | 1 | Comparator, 1 while the integrator is above zero (asynchronous) |
| int_clr_o | output | 1 | Holds the integrator at zero |
| ref_sel_o | output | 1 | Integrator source: 0 input, 1 negative reference |
| res_valid_o | output | 1 | Result available |
| res_ready_i | input | 1 | Consumer accepts the result |
| code_o | output | CODE_W | Conversion code |
| ovr_o | output | 1 | Result saturated at full scale |

## Verification
The checker watches the switch outputs and the result port on every cycle. It confirms the response to start, the exact run-up length, the overall conversion bound, the hold of the code under back-pressure, the saturated code whenever overrange is flagged, and that the integrator is never connected to the reference while it is being cleared. Whether the code matches the input ratio can only be shown by the bench scenarios. The bench drives an integer integrator model across several ratios, including an exact zero crossing at full scale, a zero input and two overrange cases. The scenarios also show that start pulses during a conversion or while a result waits leave no trace.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_RUNUP   = 2'd1,
    ST_RUNDOWN = 2'd2,
    ST_DONE    = 2'd3
  } dsc_state_e;
endpackage

// File: rtl/dsc_sync.sv
module dsc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/dsc_counter.sv
module dsc_counter #(
  parameter int CW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          inc_i,
  output logic [CW-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (clr_i)  cnt_o <= '0;
    else if (inc_i)  cnt_o <= cnt_o + CW'(1);
  end
endmodule

// File: rtl/dsc_fsm.sv
module dsc_fsm
  import dsc_pkg::*;
#(
  parameter int CODE_W = 8,
  parameter int LAT    = 2,
  parameter int CW     = CODE_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              cmp_s_i,
  input  logic [CW-1:0]     cnt_i,
  input  logic              res_ready_i,
  output logic              cnt_clr_o,
  output logic              cnt_inc_o,
  output logic              int_clr_o,
  output logic              ref_sel_o,
  output logic              res_valid_o,
  output logic [CODE_W-1:0] code_o,
  output logic              ovr_o
);
  localparam logic [CW-1:0] RUN_LAST = CW'(2**CODE_W - 1);
  localparam logic [CW-1:0] SAT_AT   = CW'(2**CODE_W - 1 + LAT);
  localparam logic [CW-1:0] LAT_V    = CW'(LAT);

  dsc_state_e        state_q, state_d;
  logic [CODE_W-1:0] code_d;
  logic              ovr_d;
  logic [CW-1:0]     adj;

  assign adj = cnt_i - LAT_V;

  always_comb begin
    state_d   = state_q;
    code_d    = code_o;
    ovr_d     = ovr_o;
    cnt_clr_o = 1'b1;
    cnt_inc_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) state_d = ST_RUNUP;
      end
      ST_RUNUP: begin
        if (cnt_i == RUN_LAST) begin
          state_d = ST_RUNDOWN;
        end else begin
          cnt_clr_o = 1'b0;
          cnt_inc_o = 1'b1;
        end
      end
      ST_RUNDOWN: begin
        if (!cmp_s_i) begin
          state_d = ST_DONE;
          code_d  = (cnt_i < LAT_V) ? '0 : adj[CODE_W-1:0];
          ovr_d   = 1'b0;
        end else if (cnt_i == SAT_AT) begin
          state_d = ST_DONE;
          code_d  = '1;
          ovr_d   = 1'b1;
        end else begin
          cnt_clr_o = 1'b0;
          cnt_inc_o = 1'b1;
        end
      end
      ST_DONE: begin
        if (res_ready_i) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      int_clr_o   <= 1'b1;
      ref_sel_o   <= 1'b0;
      res_valid_o <= 1'b0;
      code_o      <= '0;
      ovr_o       <= 1'b0;
    end else begin
      state_q     <= state_d;
      int_clr_o   <= (state_d == ST_IDLE) || (state_d == ST_DONE);
      ref_sel_o   <= (state_d == ST_RUNDOWN);
      res_valid_o <= (state_d == ST_DONE);
      code_o      <= code_d;
      ovr_o       <= ovr_d;
    end
  end
endmodule

// File: rtl/dsc_ctrl.sv
module dsc_ctrl #(
  parameter int CODE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              cmp_i,
  output logic              int_clr_o,
  output logic              ref_sel_o,
  output logic              res_valid_o,
  input  logic              res_ready_i,
  output logic [CODE_W-1:0] code_o,
  output logic              ovr_o
);
  localparam int CW = CODE_W + 2;

  logic          cmp_s;
  logic          cnt_clr, cnt_inc;
  logic [CW-1:0] cnt;

  dsc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (cmp_i),
    .q_o   (cmp_s)
  );

  dsc_counter #(.CW(CW)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (cnt_clr),
    .inc_i (cnt_inc),
    .cnt_o (cnt)
  );

  dsc_fsm #(.CODE_W(CODE_W), .LAT(SYNC_STAGES), .CW(CW)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .cmp_s_i    (cmp_s),
    .cnt_i      (cnt),
    .res_ready_i(res_ready_i),
    .cnt_clr_o  (cnt_clr),
    .cnt_inc_o  (cnt_inc),
    .int_clr_o  (int_clr_o),
    .ref_sel_o  (ref_sel_o),
    .res_valid_o(res_valid_o),
    .code_o     (code_o),
    .ovr_o      (ovr_o)
  );
endmodule

// File: rtl/dsc_ctrl_chk.sv
module dsc_ctrl_chk #(
  parameter int CODE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              cmp_i,
  input logic              int_clr_o,
  input logic              ref_sel_o,
  input logic              res_valid_o,
  input logic              res_ready_i,
  input logic [CODE_W-1:0] code_o,
  input logic              ovr_o
);
  localparam int KW = CODE_W + 3;
  localparam logic [KW-1:0] UP_LEN   = KW'(2**CODE_W);
  localparam logic [KW-1:0] BUSY_MAX = KW'(2**(CODE_W+1) + SYNC_STAGES);

  logic [KW-1:0] up_cnt, busy_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      up_cnt   <= '0;
      busy_cnt <= '0;
    end else begin
      if (int_clr_o)       up_cnt <= '0;
      else if (!ref_sel_o) up_cnt <= up_cnt + KW'(1);
      if (int_clr_o) busy_cnt <= '0;
      else           busy_cnt <= busy_cnt + KW'(1);
    end
  end

  // R2
  start_resp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_clr_o && !res_valid_o && start_i) |=> (!int_clr_o && !ref_sel_o));

  // R3
  runup_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ref_sel_o) |-> (up_cnt == UP_LEN));

  // R5
  ovr_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && ovr_o) |-> (code_o == '1));

  // R6
  hold_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && !res_ready_i) |=> (res_valid_o && $stable(code_o) && $stable(ovr_o)));

  // R6
  accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && res_ready_i) |=> !res_valid_o);

  // R7
  wait_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> (int_clr_o && !ref_sel_o));

  // R7
  ref_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_sel_o |-> !int_clr_o);

  // R8
  no_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && res_ready_i) |=> int_clr_o);

  // R9
  busy_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_cnt <= BUSY_MAX);
endmodule

bind dsc_ctrl dsc_ctrl_chk #(.CODE_W(CODE_W), .SYNC_STAGES(SYNC_STAGES)) u_chk (.*);

// File: tb/tb_dsc_ctrl.sv
module tb_dsc_ctrl;
  localparam int N      = 8;
  localparam int FULL   = 2**N;
  localparam int NVEC   = 9;
  // vin, vref, expected code, expected overrange
  localparam int VEC [NVEC][4] = '{
    '{0,   100, 0,   0},
    '{1,   256, 1,   0},
    '{100, 400, 64,  0},
    '{250, 500, 128, 0},
    '{37,  100, 95,  0},
    '{255, 256, 255, 0},
    '{256, 256, 255, 1},
    '{300, 200, 255, 1},
    '{1,   1000, 1,  0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic ready = 1'b0;
  logic int_clr, ref_sel, valid, ovr;
  logic [N-1:0] code;
  int   vin = 0, vref = 1;
  int   integ = 0;
  logic cmp;
  int   checks = 0, errors = 0;
  bit   finished = 1'b0;

  always #4 clk = ~clk;

  assign cmp = (integ > 0);

  always_ff @(posedge clk) begin
    if (int_clr)       integ <= 0;
    else if (!ref_sel) integ <= integ + vin;
    else               integ <= integ - vref;
  end

  dsc_ctrl #(.CODE_W(N), .SYNC_STAGES(2)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cmp_i(cmp),
    .int_clr_o(int_clr), .ref_sel_o(ref_sel), .res_valid_o(valid),
    .res_ready_i(ready), .code_o(code), .ovr_o(ovr)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // one conversion; optionally a stray start pulse during the run-up
  task automatic run_conv(input int v_in, input int v_ref, input int ec, input int eo,
                          input bit stray);
    int up = 0, busy = 0, guard = 0;
    vin = v_in; vref = v_ref;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(!int_clr && !ref_sel, "R2 runup entered", {int_clr, ref_sel}, 0);
    up = 1; busy = 1;
    while (!valid && guard < 3000) begin
      start = stray && (guard == 10);
      @(negedge clk);
      guard++;
      if (!int_clr && !ref_sel) up++;
      if (!int_clr) busy++;
    end
    start = 1'b0;
    chk(up == FULL, "R3 runup length", up, FULL);
    chk(code == N'(ec), "R4 code", int'(code), ec);
    chk(ovr == eo[0], "R5 overrange", int'(ovr), eo);
    chk(busy <= 2*FULL + 2, "R9 busy length", busy, 2*FULL + 2);
    chk(int_clr && !ref_sel, "R7 cleared while waiting", {int_clr, ref_sel}, 2);
    ready = 1'b1;
    @(negedge clk) ready = 1'b0;
    chk(!valid, "R6 valid dropped after accept", int'(valid), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(int_clr && !ref_sel && !valid && code == '0 && !ovr, "R1 reset outputs",
        {int_clr, ref_sel, valid, ovr}, 8);
    rst_n = 1'b1;
    @(negedge clk);
    chk(int_clr && !valid, "R1 idle after reset", {int_clr, valid}, 2);

    for (int i = 0; i < NVEC; i++)
      run_conv(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], 1'b0);

    // R8 stray start during run-up does not disturb the result
    run_conv(100, 400, 64, 0, 1'b1);

    // R6 back-pressure hold, R8 start while result waits
    vin = 37; vref = 100;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    while (!valid) @(negedge clk);
    for (int k = 0; k < 6; k++) begin
      start = (k == 2);
      @(negedge clk);
      chk(valid && code == N'(95) && !ovr, "R6 result held", int'(code), 95);
    end
    start = 1'b0;
    ready = 1'b1;
    @(negedge clk) ready = 1'b0;
    chk(!valid, "R6 accept", int'(valid), 0);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk(int_clr && !ref_sel && !valid, "R8 no conversion after ignored start",
          {int_clr, ref_sel, valid}, 4);
    end

    // R1 reset in mid conversion
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (20) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(int_clr && !ref_sel && !valid && !ovr, "R1 reset mid run", {int_clr, ref_sel}, 2);
    rst_n = 1'b1;
    run_conv(250, 500, 128, 0, 1'b0);

    finish_run();
  end
endmodule